// File: doc/BRIEF.md
# LIN node mode controller

This block holds the operating mode of a LIN slave system-basis controller and guards its transmit path. It has four modes: fail-safe (the pre-normal state after power-up or any reset, transceiver off, watchdog running), normal (transceiver on), silent and sleep (both low-power, transceiver off, inhibit output off). The host microcontroller steers the mode with the enable pin and the transmit pin. The watchdog's active-low reset output pulls the block back to fail-safe. A rising edge on the wake input, usually the ignition line, brings it out of the low-power modes.

The block drives the bus driver control from the transmit pin. A dominant-state guard counts microsecond ticks while the transmit pin is low. Once the low time passes the configured limit, it forces the driver recessive. The guard is released only when the transmit pin goes high again. The receive pin reports the synchronised bus level while the transceiver is on, and idles high otherwise.

States and transitions: FAILSAFE goes to NORMAL on a synchronised enable high. NORMAL goes to SILENT when enable falls while transmit is low. NORMAL goes to SLEEP when enable falls while transmit is high. SILENT and SLEEP go to FAILSAFE on a wake rising edge. Every state goes to FAILSAFE while the watchdog reset is low.

Top module: `lin_mode_ctrl`

## Requirements
- R1: After power-on reset the mode code is 2'b00 (fail-safe), the transceiver enable is 0, the inhibit output is 1, the driver control is 0 and the receive pin is 1.
- R2: In fail-safe, a high level on the enable pin moves the block to normal (code 2'b01) with the transceiver enable at 1. With enable low, the block stays in fail-safe.
- R3: While the watchdog reset input is low, the mode is fail-safe from the next clock edge on, whatever the previous mode.
- R4: A rising edge on the wake input moves silent or sleep to fail-safe. A wake level held high without an edge, or an edge seen in normal or fail-safe, changes nothing.
- R5: The inhibit output is 1 in fail-safe and normal, and 0 in silent (2'b10) and sleep (2'b11).
- R6: In normal mode the driver control is 1 (dominant) while the transmit pin is low and 0 (recessive) while it is high.
- R7: If the transmit pin stays low for more than DOM_LIMIT_US microsecond ticks, the driver control is forced to 0.
- R8: With the transceiver on, the receive pin follows the synchronised bus level (1 recessive, 0 dominant). With the transceiver off, it is 1.
- R9: The dominant timeout stays in force while the transmit pin stays low, and clears as soon as the pin returns high.
- R10: In normal mode, enable going low selects silent if the transmit pin is low at that moment, and sleep if it is high.
- R11: The driver control is 0 whenever the transceiver is disabled, regardless of the transmit pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick_1us | input | 1 | One-cycle pulse every microsecond |
| en_pin | input | 1 | Enable from the host (asynchronous) |
| wd_rst_n | input | 1 | Watchdog reset output, active low |
| wake_pin | input | 1 | Wake / ignition input (asynchronous) |
| txd_pin | input | 1 | Transmit data from the host, low = dominant |
| bus_level | input | 1 | Sampled bus level, 1 = recessive |
| mode | output | 2 | Mode code: 00 fail-safe, 01 normal, 10 silent, 11 sleep |
| xcvr_en | output | 1 | Transceiver enable |
| inh | output | 1 | Inhibit (external regulator switch) output |
| drv_dom | output | 1 | Bus driver control, 1 = pull bus dominant |
| rxd_pin | output | 1 | Receive data to the host |

## Verification
The mode machine is driven through every arc. Enable falls once with transmit low and once with it high, which separates the silent entry from the sleep entry. Wake is applied as a steady high, as an edge in normal mode and as an edge in each low-power mode, so edge sensitivity is told apart from level sensitivity and from mode gating. The transmit path is tried with short low pulses, with a low held past the limit and then held longer still, and with a release followed by a fresh low. This distinguishes a timeout that clears on release from one that clears by itself or never. Bus levels are applied in normal and fail-safe to show the receive pin gating.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

    typedef enum logic [1:0] {
        MODE_FAILSAFE = 2'b00,
        MODE_NORMAL   = 2'b01,
        MODE_SILENT   = 2'b10,
        MODE_SLEEP    = 2'b11
    } lin_mode_e;

endpackage

// File: rtl/lin_sync.sv
module lin_sync #(
    parameter int              WIDTH     = 1,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                pipe_q[s] <= RESET_VAL;
            end
        end else begin
            pipe_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/lin_dom_guard.sv
module lin_dom_guard #(
    parameter int LIMIT = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic txd_i,
    output logic timeout_o
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] low_cnt_q;
    logic          timeout_q;

    // Counts microsecond ticks while the transmit pin is low; the tick that
    // arrives with the count already at LIMIT marks the overrun.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
            timeout_q <= 1'b0;
        end else if (txd_i) begin
            low_cnt_q <= '0;
            timeout_q <= 1'b0;
        end else if (tick_i) begin
            if (low_cnt_q == CW'(LIMIT)) begin
                timeout_q <= 1'b1;
            end else begin
                low_cnt_q <= low_cnt_q + 1'b1;
            end
        end
    end

    assign timeout_o = timeout_q;

endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
    import lin_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  logic      wd_rst_n_i,
    input  logic      wake_rise_i,
    input  logic      txd_i,
    output lin_mode_e mode_o,
    output logic      xcvr_en_o,
    output logic      inh_o
);

    lin_mode_e state_q;
    lin_mode_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_FAILSAFE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transition logic
    always_comb begin
        state_d = state_q;
        if (!wd_rst_n_i) begin
            state_d = MODE_FAILSAFE;
        end else begin
            unique case (state_q)
                MODE_FAILSAFE: begin
                    if (en_i) state_d = MODE_NORMAL;
                end
                MODE_NORMAL: begin
                    if (!en_i) state_d = txd_i ? MODE_SLEEP : MODE_SILENT;
                end
                MODE_SILENT,
                MODE_SLEEP: begin
                    if (wake_rise_i) state_d = MODE_FAILSAFE;
                end
                default: state_d = MODE_FAILSAFE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        xcvr_en_o = 1'b0;
        inh_o     = 1'b0;
        unique case (state_q)
            MODE_FAILSAFE: begin
                xcvr_en_o = 1'b0;
                inh_o     = 1'b1;
            end
            MODE_NORMAL: begin
                xcvr_en_o = 1'b1;
                inh_o     = 1'b1;
            end
            MODE_SILENT,
            MODE_SLEEP: begin
                xcvr_en_o = 1'b0;
                inh_o     = 1'b0;
            end
            default: begin
                xcvr_en_o = 1'b0;
                inh_o     = 1'b0;
            end
        endcase
    end

    assign mode_o = state_q;

endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
    import lin_mode_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int DOM_LIMIT_US = 20000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1us,
    input  logic       en_pin,
    input  logic       wd_rst_n,
    input  logic       wake_pin,
    input  logic       txd_pin,
    input  logic       bus_level,
    output logic [1:0] mode,
    output logic       xcvr_en,
    output logic       inh,
    output logic       drv_dom,
    output logic       rxd_pin
);

    localparam int          NSYNC     = 3;
    localparam logic [NSYNC-1:0] SYNC_RST = 3'b100; // bus idles recessive

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] sync_in;
    logic             en_s;
    logic             wake_s;
    logic             bus_s;
    logic             wake_q;
    logic             wake_rise;
    logic             dom_timeout;
    lin_mode_e        mode_e;

    assign raw_in = {bus_level, wake_pin, en_pin};

    lin_sync #(
        .WIDTH    (NSYNC),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw_in),
        .q_o  (sync_in)
    );

    assign en_s   = sync_in[0];
    assign wake_s = sync_in[1];
    assign bus_s  = sync_in[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_q <= 1'b0;
        end else begin
            wake_q <= wake_s;
        end
    end

    assign wake_rise = wake_s & ~wake_q;

    lin_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_s),
        .wd_rst_n_i (wd_rst_n),
        .wake_rise_i(wake_rise),
        .txd_i      (txd_pin),
        .mode_o     (mode_e),
        .xcvr_en_o  (xcvr_en),
        .inh_o      (inh)
    );

    lin_dom_guard #(
        .LIMIT(DOM_LIMIT_US)
    ) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_1us),
        .txd_i    (txd_pin),
        .timeout_o(dom_timeout)
    );

    assign mode    = mode_e;
    assign drv_dom = xcvr_en & ~txd_pin & ~dom_timeout;
    assign rxd_pin = xcvr_en ? bus_s : 1'b1;

endmodule

// File: rtl/lin_mode_ctrl_chk.sv
module lin_mode_ctrl_chk #(
    parameter int LIMIT = 20000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_1us,
    input logic       wd_rst_n,
    input logic       txd_pin,
    input logic [1:0] mode,
    input logic       xcvr_en,
    input logic       inh,
    input logic       drv_dom,
    input logic       rxd_pin
);

    logic [31:0] low_ticks_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_ticks_q <= '0;
        end else if (txd_pin) begin
            low_ticks_q <= '0;
        end else if (tick_1us && (low_ticks_q <= 32'(LIMIT + 1))) begin
            low_ticks_q <= low_ticks_q + 32'd1;
        end
    end

    assert_wdreset_failsafe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_rst_n |=> (mode == 2'b00));

    assert_enter_normal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'b01) && ($past(mode) != 2'b01)) |-> ($past(mode) == 2'b00));

    assert_leave_lowpower_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode[1]) && (mode != $past(mode))) |-> (mode == 2'b00));

    assert_inh_with_xcvr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xcvr_en |-> inh);

    assert_drive_follows_txd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drv_dom |-> !txd_pin);

    assert_dom_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (low_ticks_q >= 32'(LIMIT + 1)) |-> !drv_dom);

    assert_rxd_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !xcvr_en |-> rxd_pin);

    assert_drive_needs_xcvr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        drv_dom |-> xcvr_en);

endmodule

bind lin_mode_ctrl lin_mode_ctrl_chk #(.LIMIT(DOM_LIMIT_US)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_1us(tick_1us),
    .wd_rst_n(wd_rst_n),
    .txd_pin (txd_pin),
    .mode    (mode),
    .xcvr_en (xcvr_en),
    .inh     (inh),
    .drv_dom (drv_dom),
    .rxd_pin (rxd_pin)
);

// File: tb/lin_mode_ctrl_tb.sv
`timescale 1ns/1ps
module lin_mode_ctrl_tb;

    localparam int LIMIT = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1us = 1'b0;
    logic       en_pin = 1'b0;
    logic       wd_rst_n = 1'b1;
    logic       wake_pin = 1'b0;
    logic       txd_pin = 1'b1;
    logic       bus_level = 1'b1;
    logic [1:0] mode;
    logic       xcvr_en;
    logic       inh;
    logic       drv_dom;
    logic       rxd_pin;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0] mode;
        logic       xcvr;
        logic       inh;
        logic       drv;
        logic       rxd;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    lin_mode_ctrl #(.SYNC_STAGES(2), .DOM_LIMIT_US(LIMIT)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_1us (tick_1us),
        .en_pin   (en_pin),
        .wd_rst_n (wd_rst_n),
        .wake_pin (wake_pin),
        .txd_pin  (txd_pin),
        .bus_level(bus_level),
        .mode     (mode),
        .xcvr_en  (xcvr_en),
        .inh      (inh),
        .drv_dom  (drv_dom),
        .rxd_pin  (rxd_pin)
    );

    // Microsecond tick: one cycle high out of every four
    initial begin
        forever begin
            repeat (3) @(posedge clk);
            #1 tick_1us = 1'b1;
            @(posedge clk);
            #1 tick_1us = 1'b0;
        end
    end

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input logic [1:0] m, input logic x, input logic ih,
                              input logic d, input logic r, input string tag);
        exp_t e;
        e.mode = m; e.xcvr = x; e.inh = ih; e.drv = d; e.rxd = r; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        #0.5;
    endtask

    // Monitor: compares queued expectations against the outputs mid-cycle
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (mode !== e.mode || xcvr_en !== e.xcvr || inh !== e.inh ||
                drv_dom !== e.drv || rxd_pin !== e.rxd) begin
                failures++;
                $display("FAIL %s: got mode=%b xcvr=%b inh=%b drv=%b rxd=%b, expected mode=%b xcvr=%b inh=%b drv=%b rxd=%b",
                         e.tag, mode, xcvr_en, inh, drv_dom, rxd_pin,
                         e.mode, e.xcvr, e.inh, e.drv, e.rxd);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        settle(3);
        // R1 reset state
        expect_out(2'b00, 0, 1, 0, 1, "R1 reset state");
        #1 rst_n = 1'b1;
        settle(6);
        expect_out(2'b00, 0, 1, 0, 1, "R2 enable low keeps fail-safe");

        // R2 enable high -> normal
        en_pin = 1'b1;
        settle(5);
        expect_out(2'b01, 1, 1, 0, 1, "R2 enable moves to normal");

        // R6 transmit pulses
        txd_pin = 1'b0;
        settle(1);
        expect_out(2'b01, 1, 1, 1, 1, "R6 txd low dominant");
        txd_pin = 1'b1;
        settle(1);
        expect_out(2'b01, 1, 1, 0, 1, "R6 txd high recessive");

        // R8 receive follows bus
        bus_level = 1'b0;
        settle(4);
        expect_out(2'b01, 1, 1, 0, 0, "R8 rxd low on dominant bus");
        bus_level = 1'b1;
        settle(4);
        expect_out(2'b01, 1, 1, 0, 1, "R8 rxd high on recessive bus");

        // R7 / R9 dominant timeout
        txd_pin = 1'b0;
        settle(60);
        expect_out(2'b01, 1, 1, 1, 1, "R7 still dominant below limit");
        settle(100);
        expect_out(2'b01, 1, 1, 0, 1, "R7 forced recessive past limit");
        settle(200);
        expect_out(2'b01, 1, 1, 0, 1, "R9 timeout held while txd low");
        txd_pin = 1'b1;
        settle(2);
        expect_out(2'b01, 1, 1, 0, 1, "R9 released recessive");
        txd_pin = 1'b0;
        settle(1);
        expect_out(2'b01, 1, 1, 1, 1, "R9 timeout cleared after release");
        txd_pin = 1'b1;
        settle(2);

        // R3 watchdog reset
        wd_rst_n = 1'b0;
        settle(2);
        expect_out(2'b00, 0, 1, 0, 1, "R3 watchdog reset to fail-safe");
        settle(5);
        expect_out(2'b00, 0, 1, 0, 1, "R3 held in fail-safe while reset low");
        wd_rst_n = 1'b1;
        settle(3);
        expect_out(2'b01, 1, 1, 0, 1, "R2 back to normal after reset");

        // R10 enable low with txd high -> sleep
        en_pin = 1'b0;
        settle(5);
        expect_out(2'b11, 0, 0, 0, 1, "R10 sleep entry / R5 inh off");

        // R4 wake edge from sleep
        wake_pin = 1'b1;
        settle(6);
        expect_out(2'b00, 0, 1, 0, 1, "R4 wake edge leaves sleep");
        settle(10);
        expect_out(2'b00, 0, 1, 0, 1, "R2 stays fail-safe with enable low");

        en_pin = 1'b1;
        settle(5);
        expect_out(2'b01, 1, 1, 0, 1, "R2 normal again");
        wake_pin = 1'b0;
        settle(5);
        wake_pin = 1'b1;
        settle(6);
        expect_out(2'b01, 1, 1, 0, 1, "R4 wake edge ignored in normal");

        // R10 enable low with txd low -> silent
        txd_pin = 1'b0;
        settle(1);
        en_pin = 1'b0;
        settle(5);
        expect_out(2'b10, 0, 0, 0, 1, "R10 silent entry / R11 drv off");
        settle(10);
        expect_out(2'b10, 0, 0, 0, 1, "R4 steady wake level no effect");
        txd_pin = 1'b1;
        wake_pin = 1'b0;
        settle(5);
        wake_pin = 1'b1;
        settle(6);
        expect_out(2'b00, 0, 1, 0, 1, "R4 wake edge leaves silent");

        // R8 / R11 with transceiver off
        bus_level = 1'b0;
        txd_pin = 1'b0;
        settle(5);
        expect_out(2'b00, 0, 1, 0, 1, "R11 R8 fail-safe drv off rxd high");
        txd_pin = 1'b1;
        bus_level = 1'b1;
        settle(3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule